// File: doc/BRIEF.md
# Call and return frame sequencer

This block performs the stack traffic behind subroutine entry and exit, and behind single-word push and pop, for a 32-bit processor. The decoder raises a one-cycle start request with an operation code and the operand values it has already read from the register file: the stack pointer (register 1), the frame pointer (register 0), the pointer register chosen for a push or pop, the value to push, the call target and the PC of the current instruction. The sequencer then runs the needed word accesses on a single-word memory port, one at a time. Each access waits for the ready handshake. When the accesses are done, it sends the register updates and the new PC back through a one-write-per-cycle register port.

A call leaves a two-word slot below the caller's stack pointer. The return address goes in the lower word, and the word above it is kept for a static chain. The old frame pointer is pushed below that slot, and the new stack top becomes the frame base. A return undoes this by working upward from the frame pointer. The operation code is 0 for call, 1 for return, 2 for push and 3 for pop.

Top module: `fsq_frame_seq`

## Requirements
- R1: A call first stores its return address at stack pointer minus 8. The return address is pc + 6 when `call_abs_i` is 1 (a literal target follows the opcode) and pc + 2 when it is 0 (the target comes from a register).
- R2: After that store completes, a call stores the old frame pointer at stack pointer minus 12.
- R3: A call then writes register 1 with stack pointer minus 12 in one cycle. In the next cycle it writes register 0 with the same value.
- R4: A return reads the word at the frame pointer, then the word at frame pointer plus 4.
- R5: A return writes register 0 with the first word read. In the next cycle it writes register 1 with frame pointer plus 12.
- R6: A push stores its value at pointer minus 4, then writes the chosen pointer register with pointer minus 4.
- R7: A pop reads the word at the pointer and writes it to the destination register. In the next cycle it writes the pointer register with pointer plus 4, so the pointer wins when both indices are equal.
- R8: While `mem_req_o` is high and `mem_ready_i` is low, the request, address, write enable and write data hold unchanged. `mem_ready_i` is ignored while no request is out.
- R9: `busy_o` rises in the cycle after a start is accepted and stays high through the last register write. It falls in the cycle after that write. No memory request or register write happens while it is low.
- R10: A start request seen while a sequence is running has no effect. The running sequence completes with the operands latched at its start, and no second sequence follows.
- R11: After reset, busy, memory request, register write and PC write are all low.
- R12: The PC write happens in the same cycle as the last register write of a call (PC = target) or of a return (PC = second word read). A memory request and a register write never share a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only when idle |
| op_i | input | 2 | 0 call, 1 return, 2 push, 3 pop |
| call_abs_i | input | 1 | Call form: 1 literal target (pc+6), 0 register target (pc+2) |
| pc_i | input | 32 | PC of the current instruction |
| target_i | input | 32 | Call destination |
| sp_i | input | 32 | Value of register 1 |
| fp_i | input | 32 | Value of register 0 |
| ptr_i | input | 32 | Value of the push/pop pointer register |
| ptr_idx_i | input | 4 | Index of the push/pop pointer register |
| val_i | input | 32 | Word to push |
| dst_idx_i | input | 4 | Destination register of a pop |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data, valid with ready |
| mem_ready_i | input | 1 | Access completes on this cycle |
| busy_o | output | 1 | Sequence in progress |
| rf_we_o | output | 1 | Register write strobe |
| rf_waddr_o | output | 4 | Register write index |
| rf_wdata_o | output | 32 | Register write value |
| pc_we_o | output | 1 | PC update strobe |
| pc_o | output | 32 | New PC |

## Verification
The assertions assume that `mem_ready_i` has a meaning only while a request is out, and that the environment may hold it low for any number of cycles. The stimulus drives ready from a pseudo-random source during idle and register-write cycles as well as during accesses, so the block has to ignore it there. The assertions also assume that start may stay high while busy. The stimulus holds start high for two cycles with a changed operation code and different operand values, so any late capture of operands shows up. Read data comes from a bench memory filled by the block's own stores, so a return reads back the frame that an earlier call built.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  typedef enum logic [1:0] {
    OP_CALL = 2'd0,
    OP_RET  = 2'd1,
    OP_PUSH = 2'd2,
    OP_POP  = 2'd3
  } fsq_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_C_RA,
    S_C_FP,
    S_C_WSP,
    S_C_WFP,
    S_R_FP,
    S_R_PC,
    S_R_WFP,
    S_R_WSP,
    S_P_ST,
    S_P_WP,
    S_Q_LD,
    S_Q_WD,
    S_Q_WP
  } fsq_state_e;

endpackage

// File: rtl/fsq_addr_calc.sv
module fsq_addr_calc #(
  parameter int DW         = 32,
  parameter int LONG_BYTES = 6,
  parameter int SHORT_BYTES = 2
) (
  input  logic          call_abs,
  input  logic [DW-1:0] pc,
  input  logic [DW-1:0] sp,
  input  logic [DW-1:0] fp,
  input  logic [DW-1:0] ptr,
  output logic [DW-1:0] ret_val,
  output logic [DW-1:0] slot_addr,
  output logic [DW-1:0] fsave_addr,
  output logic [DW-1:0] pcld_addr,
  output logic [DW-1:0] ret_sp,
  output logic [DW-1:0] push_addr,
  output logic [DW-1:0] pop_next
);
  localparam int WB = DW / 8;
  localparam logic [DW-1:0] W1   = DW'(WB);
  localparam logic [DW-1:0] W2   = DW'(2 * WB);
  localparam logic [DW-1:0] W3   = DW'(3 * WB);
  localparam logic [DW-1:0] LLEN = DW'(LONG_BYTES);
  localparam logic [DW-1:0] SLEN = DW'(SHORT_BYTES);

  always_comb begin
    ret_val    = pc + (call_abs ? LLEN : SLEN);
    slot_addr  = sp - W2;
    fsave_addr = sp - W3;
    pcld_addr  = fp + W1;
    ret_sp     = fp + W3;
    push_addr  = ptr - W1;
    pop_next   = ptr + W1;
  end
endmodule

// File: rtl/fsq_ctrl.sv
module fsq_ctrl
  import fsq_pkg::*;
#(
  parameter int DW     = 32,
  parameter int IW     = 4,
  parameter int SP_IDX = 1,
  parameter int FP_IDX = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [DW-1:0] ret_val,
  input  logic [DW-1:0] slot_addr,
  input  logic [DW-1:0] fsave_addr,
  input  logic [DW-1:0] pcld_addr,
  input  logic [DW-1:0] ret_sp,
  input  logic [DW-1:0] push_addr,
  input  logic [DW-1:0] pop_next,
  input  logic [DW-1:0] fp,
  input  logic [DW-1:0] ptr,
  input  logic [DW-1:0] target,
  input  logic [DW-1:0] val,
  input  logic [IW-1:0] ptr_idx,
  input  logic [IW-1:0] dst_idx,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          rf_we,
  output logic [IW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          pc_we,
  output logic [DW-1:0] pc_new
);
  localparam logic [IW-1:0] SPI = IW'(SP_IDX);
  localparam logic [IW-1:0] FPI = IW'(FP_IDX);

  fsq_state_e    state;
  logic [DW-1:0] l_base;    // new frame base (call) or second address (return)
  logic [DW-1:0] l_fp;
  logic [DW-1:0] l_target;
  logic [DW-1:0] l_retsp;
  logic [DW-1:0] l_ptr;
  logic [DW-1:0] l_rd0;
  logic [IW-1:0] l_pidx;
  logic [IW-1:0] l_didx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      busy      <= 1'b0;
      rf_we     <= 1'b0;
      rf_waddr  <= '0;
      rf_wdata  <= '0;
      pc_we     <= 1'b0;
      pc_new    <= '0;
      l_base    <= '0;
      l_fp      <= '0;
      l_target  <= '0;
      l_retsp   <= '0;
      l_ptr     <= '0;
      l_rd0     <= '0;
      l_pidx    <= '0;
      l_didx    <= '0;
    end else begin
      rf_we <= 1'b0;
      pc_we <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            busy     <= 1'b1;
            mem_req  <= 1'b1;
            l_fp     <= fp;
            l_target <= target;
            l_retsp  <= ret_sp;
            l_pidx   <= ptr_idx;
            l_didx   <= dst_idx;
            unique case (fsq_op_e'(op))
              OP_CALL: begin
                state     <= S_C_RA;
                mem_we    <= 1'b1;
                mem_addr  <= slot_addr;
                mem_wdata <= ret_val;
                l_base    <= fsave_addr;
              end
              OP_RET: begin
                state    <= S_R_FP;
                mem_we   <= 1'b0;
                mem_addr <= fp;
                l_base   <= pcld_addr;
              end
              OP_PUSH: begin
                state     <= S_P_ST;
                mem_we    <= 1'b1;
                mem_addr  <= push_addr;
                mem_wdata <= val;
                l_ptr     <= push_addr;
              end
              OP_POP: begin
                state    <= S_Q_LD;
                mem_we   <= 1'b0;
                mem_addr <= ptr;
                l_ptr    <= pop_next;
              end
              default: state <= S_IDLE;
            endcase
          end
        end
        S_C_RA: if (mem_ready) begin
          mem_addr  <= l_base;
          mem_wdata <= l_fp;
          state     <= S_C_FP;
        end
        S_C_FP: if (mem_ready) begin
          mem_req  <= 1'b0;
          mem_we   <= 1'b0;
          rf_we    <= 1'b1;
          rf_waddr <= SPI;
          rf_wdata <= l_base;
          state    <= S_C_WSP;
        end
        S_C_WSP: begin
          rf_we    <= 1'b1;
          rf_waddr <= FPI;
          rf_wdata <= l_base;
          pc_we    <= 1'b1;
          pc_new   <= l_target;
          state    <= S_C_WFP;
        end
        S_R_FP: if (mem_ready) begin
          l_rd0    <= mem_rdata;
          mem_addr <= l_base;
          state    <= S_R_PC;
        end
        S_R_PC: if (mem_ready) begin
          mem_req  <= 1'b0;
          rf_we    <= 1'b1;
          rf_waddr <= FPI;
          rf_wdata <= l_rd0;
          pc_new   <= mem_rdata;
          state    <= S_R_WFP;
        end
        S_R_WFP: begin
          rf_we    <= 1'b1;
          rf_waddr <= SPI;
          rf_wdata <= l_retsp;
          pc_we    <= 1'b1;
          state    <= S_R_WSP;
        end
        S_P_ST: if (mem_ready) begin
          mem_req  <= 1'b0;
          mem_we   <= 1'b0;
          rf_we    <= 1'b1;
          rf_waddr <= l_pidx;
          rf_wdata <= l_ptr;
          state    <= S_P_WP;
        end
        S_Q_LD: if (mem_ready) begin
          mem_req  <= 1'b0;
          rf_we    <= 1'b1;
          rf_waddr <= l_didx;
          rf_wdata <= mem_rdata;
          state    <= S_Q_WD;
        end
        S_Q_WD: begin
          rf_we    <= 1'b1;
          rf_waddr <= l_pidx;
          rf_wdata <= l_ptr;
          state    <= S_Q_WP;
        end
        S_C_WFP, S_R_WSP, S_P_WP, S_Q_WP: begin
          busy  <= 1'b0;
          state <= S_IDLE;
        end
        default: begin
          busy    <= 1'b0;
          mem_req <= 1'b0;
          state   <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/fsq_frame_seq.sv
module fsq_frame_seq #(
  parameter int DW          = 32,
  parameter int IW          = 4,
  parameter int SP_IDX      = 1,
  parameter int FP_IDX      = 0,
  parameter int LONG_BYTES  = 6,
  parameter int SHORT_BYTES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic          call_abs_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] target_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] fp_i,
  input  logic [DW-1:0] ptr_i,
  input  logic [IW-1:0] ptr_idx_i,
  input  logic [DW-1:0] val_i,
  input  logic [IW-1:0] dst_idx_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ready_i,
  output logic          busy_o,
  output logic          rf_we_o,
  output logic [IW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o,
  output logic          pc_we_o,
  output logic [DW-1:0] pc_o
);
  logic [DW-1:0] ret_val, slot_addr, fsave_addr, pcld_addr, ret_sp, push_addr, pop_next;

  fsq_addr_calc #(
    .DW(DW), .LONG_BYTES(LONG_BYTES), .SHORT_BYTES(SHORT_BYTES)
  ) calc_i (
    .call_abs   (call_abs_i),
    .pc         (pc_i),
    .sp         (sp_i),
    .fp         (fp_i),
    .ptr        (ptr_i),
    .ret_val    (ret_val),
    .slot_addr  (slot_addr),
    .fsave_addr (fsave_addr),
    .pcld_addr  (pcld_addr),
    .ret_sp     (ret_sp),
    .push_addr  (push_addr),
    .pop_next   (pop_next)
  );

  fsq_ctrl #(
    .DW(DW), .IW(IW), .SP_IDX(SP_IDX), .FP_IDX(FP_IDX)
  ) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start_i),
    .op         (op_i),
    .ret_val    (ret_val),
    .slot_addr  (slot_addr),
    .fsave_addr (fsave_addr),
    .pcld_addr  (pcld_addr),
    .ret_sp     (ret_sp),
    .push_addr  (push_addr),
    .pop_next   (pop_next),
    .fp         (fp_i),
    .ptr        (ptr_i),
    .target     (target_i),
    .val        (val_i),
    .ptr_idx    (ptr_idx_i),
    .dst_idx    (dst_idx_i),
    .mem_rdata  (mem_rdata_i),
    .mem_ready  (mem_ready_i),
    .mem_req    (mem_req_o),
    .mem_we     (mem_we_o),
    .mem_addr   (mem_addr_o),
    .mem_wdata  (mem_wdata_o),
    .busy       (busy_o),
    .rf_we      (rf_we_o),
    .rf_waddr   (rf_waddr_o),
    .rf_wdata   (rf_wdata_o),
    .pc_we      (pc_we_o),
    .pc_new     (pc_o)
  );
endmodule

// File: rtl/fsq_frame_seq_chk.sv
module fsq_frame_seq_chk #(
  parameter int DW     = 32,
  parameter int IW     = 4,
  parameter int SP_IDX = 1,
  parameter int FP_IDX = 0
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ready_i,
  input logic          busy_o,
  input logic          rf_we_o,
  input logic [IW-1:0] rf_waddr_o,
  input logic          pc_we_o
);
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
                                     && $stable(mem_we_o) && $stable(mem_wdata_o)));

  a_r9_req_only_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> busy_o);

  a_r9_write_only_busy: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> busy_o);

  a_r9_fall_after_write: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(rf_we_o));

  a_r10_rise_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

  a_r12_pc_with_frame_write: assert property (@(posedge clk) disable iff (rst)
    pc_we_o |-> (rf_we_o && (rf_waddr_o == IW'(SP_IDX) || rf_waddr_o == IW'(FP_IDX))));

  a_r12_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(mem_req_o && rf_we_o));
endmodule

bind fsq_frame_seq fsq_frame_seq_chk #(
  .DW(DW), .IW(IW), .SP_IDX(SP_IDX), .FP_IDX(FP_IDX)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i),
  .busy_o      (busy_o),
  .rf_we_o     (rf_we_o),
  .rf_waddr_o  (rf_waddr_o),
  .pc_we_o     (pc_we_o)
);

// File: tb/fsq_frame_seq_tb.sv
module fsq_frame_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic        call_abs_i = 1'b0;
  logic [31:0] pc_i = '0, target_i = '0, sp_i = '0, fp_i = '0, ptr_i = '0, val_i = '0;
  logic [3:0]  ptr_idx_i = '0, dst_idx_i = '0;
  logic        mem_req_o, mem_we_o, busy_o, rf_we_o, pc_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o, rf_wdata_o, pc_o;
  logic [3:0]  rf_waddr_o;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_ready_i = 1'b0;

  always #2.5 clk = ~clk;

  fsq_frame_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .call_abs_i(call_abs_i),
    .pc_i(pc_i), .target_i(target_i), .sp_i(sp_i), .fp_i(fp_i), .ptr_i(ptr_i),
    .ptr_idx_i(ptr_idx_i), .val_i(val_i), .dst_idx_i(dst_idx_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i),
    .busy_o(busy_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .pc_we_o(pc_we_o), .pc_o(pc_o)
  );

  typedef struct {
    bit          m;
    bit          we;
    logic [31:0] addr;
    logic [31:0] v;
    int          src;
    int          idx;
    bit          pc;
    logic [31:0] pcv;
    int          pcsrc;
    string       tag;
  } act_t;

  act_t        q[$];
  logic [31:0] rdv[2];
  int          rdn;
  bit          stalled;
  logic [31:0] regs[16];
  logic [31:0] mem_m[logic [31:0]];
  int          checks = 0, errors = 0, cyc = 0;
  bit          began = 0, rand_ready = 0;

  function automatic act_t mk_mem(bit we, logic [31:0] a, logic [31:0] d, string t);
    act_t e;
    e.m = 1; e.we = we; e.addr = a; e.v = d; e.src = 0; e.idx = 0;
    e.pc = 0; e.pcv = 0; e.pcsrc = 0; e.tag = t;
    return e;
  endfunction

  function automatic act_t mk_reg(int i, logic [31:0] d, int s, bit p, logic [31:0] pv,
                                  int ps, string t);
    act_t e;
    e.m = 0; e.we = 0; e.addr = 0; e.v = d; e.src = s; e.idx = i;
    e.pc = p; e.pcv = pv; e.pcsrc = ps; e.tag = t;
    return e;
  endfunction

  function automatic logic [31:0] pick(logic [31:0] c, int s);
    return (s == 0) ? c : rdv[s-1];
  endfunction

  function automatic logic [31:0] mem_rd(logic [31:0] a);
    return mem_m.exists(a) ? mem_m[a] : 32'hDEAD_0000 ^ a;
  endfunction

  // Behavioural reference: a queue of expected port actions per sequence.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      q.delete();
      stalled = 0;
    end else if (q.size() == 0) begin
      if (start_i) begin
        rdn = 0;
        stalled = 0;
        case (op_i)
          2'd0: begin
            q.push_back(mk_mem(1, sp_i - 8, pc_i + (call_abs_i ? 32'd6 : 32'd2), "R1"));
            q.push_back(mk_mem(1, sp_i - 12, fp_i, "R2"));
            q.push_back(mk_reg(1, sp_i - 12, 0, 0, 0, 0, "R3"));
            q.push_back(mk_reg(0, sp_i - 12, 0, 1, target_i, 0, "R3"));
          end
          2'd1: begin
            q.push_back(mk_mem(0, fp_i, 0, "R4"));
            q.push_back(mk_mem(0, fp_i + 4, 0, "R4"));
            q.push_back(mk_reg(0, 0, 1, 0, 0, 0, "R5"));
            q.push_back(mk_reg(1, fp_i + 12, 0, 1, 0, 2, "R5"));
          end
          2'd2: begin
            q.push_back(mk_mem(1, ptr_i - 4, val_i, "R6"));
            q.push_back(mk_reg(int'(ptr_idx_i), ptr_i - 4, 0, 0, 0, 0, "R6"));
          end
          default: begin
            q.push_back(mk_mem(0, ptr_i, 0, "R7"));
            q.push_back(mk_reg(int'(dst_idx_i), 0, 1, 0, 0, 0, "R7"));
            q.push_back(mk_reg(int'(ptr_idx_i), ptr_i + 4, 0, 0, 0, 0, "R7"));
          end
        endcase
      end
    end else if (q[0].m) begin
      if (mem_ready_i) begin
        if (q[0].we) mem_m[q[0].addr] = q[0].v;
        else begin rdv[rdn] = mem_rdata_i; rdn = rdn + 1; end
        void'(q.pop_front());
        stalled = 0;
      end else stalled = 1;
    end else begin
      regs[q[0].idx] = pick(q[0].v, q[0].src);
      void'(q.pop_front());
    end
  end

  // Compare every cycle, then drive memory responses for the next edge.
  always @(negedge clk) begin
    logic [136:0] act, exp;
    string t;
    if (began) begin
      act = {busy_o, mem_req_o, mem_we_o, mem_req_o ? mem_addr_o : 32'h0,
             (mem_req_o && mem_we_o) ? mem_wdata_o : 32'h0, rf_we_o,
             rf_we_o ? rf_waddr_o : 4'h0, rf_we_o ? rf_wdata_o : 32'h0,
             pc_we_o, pc_we_o ? pc_o : 32'h0};
      if (rst || q.size() == 0) begin
        exp = '0;
        t = rst ? "R11" : "R9";
      end else if (q[0].m) begin
        exp = {1'b1, 1'b1, q[0].we, q[0].addr, q[0].we ? q[0].v : 32'h0,
               1'b0, 4'h0, 32'h0, 1'b0, 32'h0};
        t = stalled ? "R8" : q[0].tag;
      end else begin
        exp = {1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 4'(q[0].idx),
               pick(q[0].v, q[0].src), q[0].pc,
               q[0].pc ? pick(q[0].pcv, q[0].pcsrc) : 32'h0};
        t = q[0].pc ? {q[0].tag, "/R12"} : q[0].tag;
      end
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s cycle %0d actual %h expected %h", t, cyc, act, exp);
      end
    end
    mem_ready_i = rand_ready ? ($urandom_range(0, 99) < 55) : 1'b1;
    mem_rdata_i = (q.size() != 0 && q[0].m) ? mem_rd(q[0].addr) : $urandom;
  end

  task automatic run_op(input int op, input bit abs_f, input logic [31:0] pc,
                        input logic [31:0] tgt, input int pidx, input logic [31:0] v,
                        input int didx, input int hold);
    @(negedge clk);
    start_i = 1; op_i = 2'(op); call_abs_i = abs_f; pc_i = pc; target_i = tgt;
    sp_i = regs[1]; fp_i = regs[0]; ptr_i = regs[pidx];
    ptr_idx_i = 4'(pidx); val_i = v; dst_idx_i = 4'(didx);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      op_i = 2'd2; sp_i = 32'h5555_0000; fp_i = 32'h6666_0000; ptr_i = 32'h7777_0000;
      ptr_idx_i = 4'd9; val_i = 32'hBAD0_BAD0; target_i = 32'hFFFF_0000;
    end
    @(negedge clk);
    start_i = 0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h100 * i;
    regs[1] = 32'h0000_1000;
    regs[0] = 32'h0000_2000;
    repeat (2) @(posedge clk);
    began = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    run_op(2, 0, 0, 0, 1, 32'h0000_A5A5, 0, 0);             // R6 push on stack pointer
    run_op(0, 1, 32'h100, 32'h400, 0, 0, 0, 0);              // R1 literal call
    run_op(0, 0, 32'h404, 32'h800, 0, 0, 0, 0);              // R1 register call
    rand_ready = 1;
    run_op(2, 0, 0, 0, 7, 32'h1234_5678, 0, 0);             // R6 push on r7
    run_op(3, 0, 0, 0, 7, 0, 5, 0);                          // R7 pop into r5
    run_op(1, 0, 0, 0, 0, 0, 0, 0);                          // R4 R5 return
    run_op(1, 0, 0, 0, 0, 0, 0, 0);                          // R4 R5 return
    run_op(3, 0, 0, 0, 1, 0, 3, 0);                          // R7 pop into r3
    run_op(2, 0, 0, 0, 6, 32'h0BAD_F00D, 0, 0);
    run_op(3, 0, 0, 0, 6, 0, 6, 0);                          // R7 dst equals pointer
    run_op(0, 1, 32'h900, 32'hC00, 0, 0, 0, 2);              // R10 start held while busy
    checks++;
    if (busy_o !== 1'b0 || mem_req_o !== 1'b0) begin
      errors++;
      $display("FAIL R10 actual busy %b req %b expected 0 0", busy_o, mem_req_o);
    end
    checks++;
    if (regs[5] !== 32'h1234_5678) begin
      errors++;
      $display("FAIL R7 actual %h expected %h", regs[5], 32'h1234_5678);
    end
    checks++;
    if (regs[3] !== 32'h0000_A5A5 || regs[1] !== 32'h0000_1000 - 12) begin
      errors++;
      $display("FAIL R5 actual %h %h expected %h %h", regs[3], regs[1],
               32'h0000_A5A5, 32'h0000_1000 - 12);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 20000);
    errors++;
    $display("FAIL watchdog actual %0d cycles expected completion", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule